// File: doc/BRIEF.md
# Drive Write-Protect Override and Speed-Flag Glue

This block sits next to the small 8-bit processor inside a floppy drive and gives the firmware two side channels that work without any data writes. The only way to steer it is to read from one of two address windows. It watches the processor's address bus and read strobe. The rising edge of each read strobe clocks one of two internal flip-flops when the address falls in a decoded window.

The first flip-flop sits in the write-protect path from the drive mechanism to the disk controller. When the override jumper is fitted, the flip-flop can invert that path, so a protected disk can look writable or the other way round. The controller status then shows the possibly inverted value.

The second flip-flop drives the processor's active-low set-overflow pin. Firmware clears the overflow flag and reads the speed window four times. If the mode switch is set to fast, the pin falls at least once and the flag ends up set. If the switch is set to slow, the pin never moves and the flag stays clear. A read of the speed window also cancels any write-protect inversion.

All pins are plain control signals. The block carries no data stream, so it has no valid/ready handshake.

Top module: `drive_wp_glue`

## Requirements
- R1: After a synchronous reset the write-protect inversion is off, `wp_gated` equals `wp_raw` and `set_ovf_n` is high.
- R2: With `ovr_jumper` high, each read strobe whose address has A15..A14 = 01 (0x4000–0x7FFF) toggles the inversion, so `wp_gated` becomes the complement of `wp_raw`, and a second such read restores it.
- R3: A read strobe whose address has A15..A11 = 10011 (0x9800–0x9FFF) turns the inversion off, whether or not it was on.
- R4: With `ovr_jumper` low, `wp_gated` always equals `wp_raw`. Reads of the 0x4000 window leave the inversion untouched, so fitting the jumper afterwards still shows no inversion.
- R5: With `speed_fast` high, each read strobe in the 0x9800 window toggles `set_ovf_n`. Four consecutive reads from reset give exactly two falling edges and leave the pin high.
- R6: With `speed_fast` low, reads of the 0x9800 window leave `set_ovf_n` unchanged.
- R7: A read strobe held high for several clock cycles acts exactly once, on its first cycle.
- R8: Read strobes at addresses outside both windows (for example 0x3FFF, 0x8000, 0x9000, 0xA000) change neither output.
- R9: `wp_gated` follows changes of `wp_raw` in the same cycle, with the current inversion applied.
- R10: An address inside a window with no read strobe changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Processor address bus |
| rd_strb | input | 1 | Read strobe, active high, synchronous to clk |
| wp_raw | input | 1 | Write-protect line from the mechanism (1 = protected) |
| speed_fast | input | 1 | Mode switch (1 = fast) |
| ovr_jumper | input | 1 | 1 = software override of write protect allowed |
| wp_gated | output | 1 | Write-protect line passed on to the disk controller |
| set_ovf_n | output | 1 | Active-low set-overflow pin of the processor |

## Verification
A stuck or wrongly toggled inversion flip-flop shows up at `wp_gated` in the first cycle after the read strobe that clocks it. It remains visible until a read of the speed window clears it, so each window read is followed by a port check. A fault in the speed flip-flop changes the level of `set_ovf_n` one cycle after the strobe. The bench also counts falling edges across a four-read burst, because an extra or missing toggle shifts both the edge count and the final level. A faulty strobe edge detector shows up as a second toggle during a long strobe, which makes the inversion return to its previous state.

// File: rtl/drive_wp_glue_pkg.sv
package drive_wp_glue_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned WP_BITS  = 2;
  localparam logic [WP_BITS-1:0]  WP_PAT  = 2'b01;
  localparam int unsigned SPD_BITS = 5;
  localparam logic [SPD_BITS-1:0] SPD_PAT = 5'b10011;

  typedef struct packed {
    logic wp_win;
    logic spd_win;
  } win_hits_t;
endpackage

// File: rtl/win_match.sv
module win_match #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NBITS  = 2,
  parameter logic [NBITS-1:0] PAT = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned LSB = ADDR_W - NBITS;
  assign hit_o = (addr_i[ADDR_W-1:LSB] == PAT);
endmodule

// File: rtl/strobe_edge.sv
module strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic rd_i,
  output logic rise_o
);
  logic rd_q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_i;
  end

  assign rise_o = rd_i & ~rd_q;

  // R7
  single_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/wp_invert.sv
module wp_invert (
  input  logic clk,
  input  logic rst,
  input  logic tog_i,
  input  logic clr_i,
  input  logic ovr_en_i,
  input  logic wp_raw_i,
  output logic wp_o
);
  logic inv_q;

  always_ff @(posedge clk) begin
    if (rst)                   inv_q <= 1'b0;
    else if (clr_i)            inv_q <= 1'b0;
    else if (tog_i && ovr_en_i) inv_q <= ~inv_q;
  end

  assign wp_o = wp_raw_i ^ (inv_q & ovr_en_i);

  // R3
  clear_inv_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !inv_q);

  // R4
  locked_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (!ovr_en_i && !clr_i) |=> $stable(inv_q));

  // R10
  idle_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (!tog_i && !clr_i) |=> $stable(inv_q));
endmodule

// File: rtl/speed_pulse.sv
module speed_pulse (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  input  logic fast_i,
  output logic set_ovf_n_o
);
  logic tog_q;

  always_ff @(posedge clk) begin
    if (rst)                 tog_q <= 1'b0;
    else if (hit_i && fast_i) tog_q <= ~tog_q;
  end

  assign set_ovf_n_o = ~tog_q;

  // R5
  fast_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_i && fast_i) |=> (set_ovf_n_o != $past(set_ovf_n_o)));

  // R6
  slow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fast_i |=> $stable(set_ovf_n_o));
endmodule

// File: rtl/drive_wp_glue.sv
module drive_wp_glue
  import drive_wp_glue_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_strb,
  input  logic              wp_raw,
  input  logic              speed_fast,
  input  logic              ovr_jumper,
  output logic              wp_gated,
  output logic              set_ovf_n
);
  win_hits_t hits;
  logic      rd_rise;

  localparam int unsigned NWIN = 2;
  localparam int unsigned WBITS [NWIN] = '{WP_BITS, SPD_BITS};

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    if (g == 0) begin : g_wp
      win_match #(.ADDR_W(ADDR_W), .NBITS(WBITS[g]), .PAT(WP_PAT))
        u_match (.addr_i(addr), .hit_o(hits.wp_win));
    end else begin : g_spd
      win_match #(.ADDR_W(ADDR_W), .NBITS(WBITS[g]), .PAT(SPD_PAT))
        u_match (.addr_i(addr), .hit_o(hits.spd_win));
    end
  end

  strobe_edge u_edge (
    .clk(clk), .rst(rst), .rd_i(rd_strb), .rise_o(rd_rise)
  );

  wp_invert u_wp (
    .clk(clk), .rst(rst),
    .tog_i(rd_rise & hits.wp_win),
    .clr_i(rd_rise & hits.spd_win),
    .ovr_en_i(ovr_jumper),
    .wp_raw_i(wp_raw),
    .wp_o(wp_gated)
  );

  speed_pulse u_spd (
    .clk(clk), .rst(rst),
    .hit_i(rd_rise & hits.spd_win),
    .fast_i(speed_fast),
    .set_ovf_n_o(set_ovf_n)
  );

  // R8
  outside_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!hits.wp_win && !hits.spd_win) |=> $stable(set_ovf_n));

  // R2
  wp_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_rise && hits.wp_win && ovr_jumper && $stable(wp_raw)) |=>
      (wp_gated != $past(wp_gated)) || !ovr_jumper || !$stable(wp_raw));
endmodule

// File: tb/test_drive_wp_glue.sv
module test_drive_wp_glue;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic        rd_strb = 1'b0;
  logic        wp_raw = 1'b0;
  logic        speed_fast = 1'b0;
  logic        ovr_jumper = 1'b1;
  logic        wp_gated;
  logic        set_ovf_n;

  int n_chk = 0;
  int n_fail = 0;
  int falls = 0;
  bit done = 0;

  always #2 clk = ~clk;

  drive_wp_glue i_drive_wp_glue (
    .clk(clk), .rst(rst), .addr(addr), .rd_strb(rd_strb), .wp_raw(wp_raw),
    .speed_fast(speed_fast), .ovr_jumper(ovr_jumper),
    .wp_gated(wp_gated), .set_ovf_n(set_ovf_n)
  );

  always @(negedge set_ovf_n) if (!rst) falls++;

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; rd_strb = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0; falls = 0;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [15:0] a, input int hold);
    @(negedge clk); addr = a; rd_strb = 1'b1;
    repeat (hold) @(negedge clk);
    rd_strb = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    ovr_jumper = 1'b1; speed_fast = 1'b1;
    do_read(16'h4000, 1);
    do_read(16'h9800, 1);
    do_reset();
    wp_raw = 1'b1; #1;
    chk(wp_gated, 1'b1, "R1 wp pass");
    chk(set_ovf_n, 1'b1, "R1 ovf idle");
  endtask

  task automatic t_toggle();
    do_reset(); ovr_jumper = 1'b1; wp_raw = 1'b0;
    do_read(16'h4000, 1);
    chk(wp_gated, 1'b1, "R2 first toggle");
    wp_raw = 1'b1; #1;
    chk(wp_gated, 1'b0, "R9 follows raw inverted");
    do_read(16'h7FFF, 1);
    chk(wp_gated, 1'b1, "R2 second toggle");
    wp_raw = 1'b0; #1;
    chk(wp_gated, 1'b0, "R9 follows raw plain");
  endtask

  task automatic t_clear();
    do_reset(); ovr_jumper = 1'b1; wp_raw = 1'b1; speed_fast = 1'b0;
    do_read(16'h5A5A, 1);
    chk(wp_gated, 1'b0, "R3 setup inverted");
    do_read(16'h9FFF, 1);
    chk(wp_gated, 1'b1, "R3 cleared");
    do_read(16'h9800, 1);
    chk(wp_gated, 1'b1, "R3 clear when already off");
  endtask

  task automatic t_jumper();
    do_reset(); ovr_jumper = 1'b0; wp_raw = 1'b1;
    do_read(16'h4000, 1);
    chk(wp_gated, 1'b1, "R4 no jumper");
    do_read(16'h6000, 1);
    do_read(16'h4001, 1);
    chk(wp_gated, 1'b1, "R4 no jumper repeated");
    ovr_jumper = 1'b1; #1;
    chk(wp_gated, 1'b1, "R4 state untouched");
  endtask

  task automatic t_fast();
    do_reset(); speed_fast = 1'b1;
    do_read(16'h9800, 1);
    chk(set_ovf_n, 1'b0, "R5 read 1");
    do_read(16'h9A00, 1);
    chk(set_ovf_n, 1'b1, "R5 read 2");
    do_read(16'h9C01, 1);
    do_read(16'h9FFF, 1);
    chk(set_ovf_n, 1'b1, "R5 end high");
    chk(falls == 2, 1'b1, "R5 two falling edges");
  endtask

  task automatic t_slow();
    do_reset(); speed_fast = 1'b0;
    for (int i = 0; i < 4; i++) do_read(16'h9800 + 16'(i), 1);
    chk(set_ovf_n, 1'b1, "R6 slow level");
    chk(falls == 0, 1'b1, "R6 no edges");
  endtask

  task automatic t_long();
    do_reset(); ovr_jumper = 1'b1; wp_raw = 1'b0; speed_fast = 1'b1;
    do_read(16'h4000, 6);
    chk(wp_gated, 1'b1, "R7 long wp strobe");
    do_read(16'h9800, 5);
    chk(set_ovf_n, 1'b0, "R7 long speed strobe");
    chk(falls == 1, 1'b1, "R7 one edge");
  endtask

  task automatic t_other();
    do_reset(); ovr_jumper = 1'b1; wp_raw = 1'b0; speed_fast = 1'b1;
    do_read(16'h3FFF, 1);
    do_read(16'h8000, 1);
    do_read(16'h9000, 1);
    do_read(16'hA000, 1);
    chk(wp_gated, 1'b0, "R8 wp untouched");
    chk(set_ovf_n, 1'b1, "R8 ovf untouched");
  endtask

  task automatic t_nostrobe();
    do_reset(); ovr_jumper = 1'b1; wp_raw = 1'b0; speed_fast = 1'b1;
    @(negedge clk); addr = 16'h4000;
    repeat (3) @(negedge clk);
    addr = 16'h9800;
    repeat (3) @(negedge clk);
    chk(wp_gated, 1'b0, "R10 wp idle");
    chk(set_ovf_n, 1'b1, "R10 ovf idle");
  endtask

  initial begin
    t_reset();
    t_toggle();
    t_clear();
    t_jumper();
    t_fast();
    t_slow();
    t_long();
    t_other();
    t_nostrobe();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule